// File: doc/BRIEF.md
# Converter Chain Reset, Sync and Configuration Sequencer

This block sits on the host side of a chain of sigma-delta converters that share one master clock. It generates that master clock by dividing the system clock. On a start command it walks the chain through a fixed order: an active-low reset pulse, an active-low SYNC pulse, a wait for the filter start edge, and one 32-bit register write. The write is shifted on a serial data line while a frame strobe is held low. The chain passes a frame loaded at its head on to every device, so a single frame configures all of them. A typical use is the power-mode register at address 0x0001.

A separate decimation-change request runs only the SYNC part again, with no reset and no write. The converters' filters are then realigned before their data is trusted. Pulse widths are counted in master-clock periods, and every edge on the converter-facing lines lands on a master-clock falling edge. The master clock also serves as the serial clock. Serial data changes on its falling edge and is stable on its rising edge.

Top module: `adc_chain_sequencer`

## Requirements
- R1: After the controller reset (rst_n low), adc_rst_n, adc_sync_n and fsi_n are 1, sdi, busy and done are 0. mclk toggles every MCLK_HALF system clocks, so one master period is 2*MCLK_HALF clocks.
- R2: A start accepted while idle drives adc_rst_n low at the next mclk falling edge. It stays low for exactly RST_CYC master periods (default 2) and rises together with an mclk falling edge.
- R3: adc_sync_n falls on the mclk falling edge where adc_rst_n rises. It stays low for exactly SYNC_CYC master periods (default 8, at least 4) and rises on an mclk falling edge.
- R4: The first mclk falling edge after adc_sync_n rises is the sync reference. On a start sequence fsi_n goes low at that edge, one master period before the first data bit.
- R5: A frame is 32 bits: the 16-bit address, then the 16-bit data, MSB first. Each bit is placed on sdi at an mclk falling edge, and fsi_n stays low throughout. fsi_n returns high at the mclk falling edge after the 32nd bit. sdi is 0 whenever fsi_n is high.
- R6: fsi_n is never low while adc_rst_n or adc_sync_n is low.
- R7: busy is high from the clock after a command is accepted until the sequence ends. done rises together with busy falling and stays high until the next accepted command. done and busy are never both high.
- R8: dec_change accepted while idle produces a SYNC_CYC-period SYNC pulse starting at the next mclk falling edge, without any reset pulse. One falling edge after SYNC rises, the sequence finishes with no frame.
- R9: start and dec_change are ignored while busy: the running sequence is unchanged, and no new sequence follows it.
- R10: cfg_addr and cfg_data are captured when start is accepted. Later changes on these inputs do not alter the frame.
- R11: When start and dec_change are both high in the accepting cycle, start wins and the full sequence runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous controller reset |
| start | input | 1 | Request the full reset, sync and write sequence |
| dec_change | input | 1 | Decimation was changed; request a resync |
| cfg_addr | input | 16 | Register address for the write frame |
| cfg_data | input | 16 | Register data for the write frame |
| mclk | output | 1 | Master clock to the converters, also used as the serial clock |
| adc_rst_n | output | 1 | Common active-low converter reset |
| adc_sync_n | output | 1 | Common active-low SYNC |
| fsi_n | output | 1 | Active-low frame strobe for the write |
| sdi | output | 1 | Serial write data, MSB first |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last sequence completed |

## Verification
The hardest case to reach from the ports is a command arriving while a sequence is already running. Its effect can only be judged by comparing the entire edge-by-edge output stream against an uninterrupted one, and by watching the idle period afterwards. The bench launches each command one system clock after an observed master falling edge, so the expected stream can be indexed by falling edges. Mid-sequence it pulses start and dec_change with different configuration values. It then demands both an unaltered frame and three idle master periods after completion. The same framing checks that a same-cycle start and dec_change yields the full sequence.

// File: rtl/adc_chain_sequencer.sv
module adc_chain_sequencer #(
  parameter int MCLK_HALF = 2,
  parameter int RST_CYC   = 2,
  parameter int SYNC_CYC  = 8,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              dec_change,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_data,
  output logic              mclk,
  output logic              adc_rst_n,
  output logic              adc_sync_n,
  output logic              fsi_n,
  output logic              sdi,
  output logic              busy,
  output logic              done
);
  localparam int FRAME_W = ADDR_W + DATA_W;
  localparam int DIV_W   = $clog2(MCLK_HALF) + 1;
  localparam int CNT_W   = $clog2(FRAME_W + RST_CYC + SYNC_CYC + 2) + 1;
  localparam logic [DIV_W-1:0] DIV_LAST  = DIV_W'(MCLK_HALF - 1);
  localparam logic [CNT_W-1:0] RST_LAST  = CNT_W'(RST_CYC - 1);
  localparam logic [CNT_W-1:0] SYNC_LAST = CNT_W'(SYNC_CYC - 1);
  localparam logic [CNT_W-1:0] BITS      = CNT_W'(FRAME_W);

  typedef enum logic [2:0] {S_IDLE, S_ARM, S_RST, S_SYNC, S_REF, S_SHIFT} state_t;

  state_t             state;
  logic [DIV_W-1:0]   div;
  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-1:0] shreg;
  logic               with_wr;
  logic               fall_tick;

  assign fall_tick = mclk && (div == DIV_LAST);
  assign busy      = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div  <= '0;
      mclk <= 1'b0;
    end else if (div == DIV_LAST) begin
      div  <= '0;
      mclk <= ~mclk;
    end else begin
      div <= div + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cnt        <= '0;
      shreg      <= '0;
      with_wr    <= 1'b0;
      adc_rst_n  <= 1'b1;
      adc_sync_n <= 1'b1;
      fsi_n      <= 1'b1;
      sdi        <= 1'b0;
      done       <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (start) begin
            state   <= S_ARM;
            with_wr <= 1'b1;
            shreg   <= {cfg_addr, cfg_data};
            done    <= 1'b0;
          end else if (dec_change) begin
            state   <= S_ARM;
            with_wr <= 1'b0;
            done    <= 1'b0;
          end
        end
        S_ARM: if (fall_tick) begin
          cnt <= '0;
          if (with_wr) begin
            adc_rst_n <= 1'b0;
            state     <= S_RST;
          end else begin
            adc_sync_n <= 1'b0;
            state      <= S_SYNC;
          end
        end
        S_RST: if (fall_tick) begin
          if (cnt == RST_LAST) begin
            adc_rst_n  <= 1'b1;
            adc_sync_n <= 1'b0;
            cnt        <= '0;
            state      <= S_SYNC;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_SYNC: if (fall_tick) begin
          if (cnt == SYNC_LAST) begin
            adc_sync_n <= 1'b1;
            state      <= S_REF;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_REF: if (fall_tick) begin
          cnt <= '0;
          if (with_wr) begin
            fsi_n <= 1'b0;
            state <= S_SHIFT;
          end else begin
            done  <= 1'b1;
            state <= S_IDLE;
          end
        end
        S_SHIFT: if (fall_tick) begin
          if (cnt == BITS) begin
            fsi_n <= 1'b1;
            sdi   <= 1'b0;
            done  <= 1'b1;
            state <= S_IDLE;
          end else begin
            sdi   <= shreg[FRAME_W-1];
            shreg <= {shreg[FRAME_W-2:0], 1'b0};
            cnt   <= cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  localparam logic [15:0] RST_CLKS  = 16'(RST_CYC * 2 * MCLK_HALF);
  localparam logic [15:0] SYNC_CLKS = 16'(SYNC_CYC * 2 * MCLK_HALF);
  logic [15:0] rlow, slow;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rlow <= '0;
      slow <= '0;
    end else begin
      rlow <= adc_rst_n  ? 16'd0 : rlow + 16'd1;
      slow <= adc_sync_n ? 16'd0 : slow + 16'd1;
    end
  end

  a_r2_rst_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_rst_n) |-> rlow == RST_CLKS);
  a_r2_rst_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_rst_n) |-> $fell(mclk));
  a_r3_sync_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_sync_n) |-> slow == SYNC_CLKS);
  a_r3_sync_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_sync_n) |-> $fell(mclk));
  a_r5_sdi_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdi) |-> $fell(mclk));
  a_r5_sdi_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    fsi_n |-> !sdi);
  a_r6_frame_after_sync: assert property (@(posedge clk) disable iff (!rst_n)
    !fsi_n |-> (adc_sync_n && adc_rst_n));
  a_r7_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: tb/adc_chain_sequencer_bench.sv
`timescale 1ns/1ps
module adc_chain_sequencer_bench;
  localparam int HALF = 2, RC = 2, SC = 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, dec_change = 1'b0;
  logic [15:0] cfg_addr = '0, cfg_data = '0;
  logic mclk, adc_rst_n, adc_sync_n, fsi_n, sdi, busy, done;

  always #2.5 clk = ~clk;

  adc_chain_sequencer u_adc_chain_sequencer (
    .clk(clk), .rst_n(rst_n), .start(start), .dec_change(dec_change),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .mclk(mclk),
    .adc_rst_n(adc_rst_n), .adc_sync_n(adc_sync_n), .fsi_n(fsi_n),
    .sdi(sdi), .busy(busy), .done(done));

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  logic [5:0] q_exp[$];
  string      q_tag[$];
  logic       mprev = 1'b0;

  function automatic logic [5:0] snap();
    return {adc_rst_n, adc_sync_n, fsi_n, sdi, busy, done};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void push(input logic [5:0] v, input string t);
    q_exp.push_back(v);
    q_tag.push_back(t);
  endfunction

  always @(negedge clk) begin
    if (rst_n && mprev && !mclk) begin
      check("R6 frame strobe outside reset/sync", {31'd0, !fsi_n && (!adc_rst_n || !adc_sync_n)}, 32'd0);
      if (q_exp.size() > 0) begin
        logic [5:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        check({t, " {rst,sync,fsi,sdi,busy,done}"}, {26'd0, snap()}, {26'd0, e});
      end
    end
    mprev = mclk;
  end

  task automatic wait_fall();
    logic p;
    p = mclk;
    forever begin
      @(negedge clk);
      if (p && !mclk) break;
      p = mclk;
    end
  endtask

  task automatic exp_full(input logic [31:0] w, input string bt);
    for (int i = 0; i < RC; i++) push(6'b011010, "R2");
    for (int i = 0; i < SC; i++) push(6'b101010, "R3");
    push(6'b111010, "R3");
    push(6'b110010, "R4");
    for (int b = 31; b >= 0; b--) push({3'b110, w[b], 2'b10}, bt);
    push(6'b111001, "R7");
  endtask

  task automatic exp_dec();
    for (int i = 0; i < SC; i++) push(6'b101010, "R8");
    push(6'b111010, "R8");
    push(6'b111001, "R8");
  endtask

  task automatic drain();
    while (q_exp.size() != 0) @(negedge clk);
  endtask

  task automatic cmd(input logic s, input logic d, input logic [15:0] a, input logic [15:0] v);
    wait_fall();
    start = s; dec_change = d; cfg_addr = a; cfg_data = v;
    @(negedge clk);
    start = 0; dec_change = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R1 reset outputs", {26'd0, snap()}, {26'd0, 6'b111000});
    rst_n = 1'b1;
    wait_fall();
    begin
      int n = 0;
      do begin @(negedge clk); n++; end while (!(mprev && !mclk));
      check("R1 mclk period", n, 2 * HALF);
    end
    check("R1 idle after reset", {26'd0, snap()}, {26'd0, 6'b111000});

    // R2 R3 R4 R5: power-mode write
    cmd(1, 0, 16'h0001, 16'h0A5C);
    exp_full(32'h0001_0A5C, "R5");
    drain();

    // R10: inputs changed right after acceptance
    cmd(1, 0, 16'hC3E1, 16'h8F07);
    cfg_addr = 16'h1234; cfg_data = 16'h5678;
    exp_full(32'hC3E1_8F07, "R10");
    drain();

    // R8: decimation change resync
    cmd(0, 1, 16'hFFFF, 16'hFFFF);
    exp_dec();
    drain();

    // R9: commands while busy are ignored
    cmd(1, 0, 16'h8001, 16'hFFFF);
    exp_full(32'h8001_FFFF, "R9");
    repeat (23) @(negedge clk);
    start = 1; cfg_addr = 16'h0000; cfg_data = 16'h0000;
    @(negedge clk); start = 0;
    repeat (9) @(negedge clk);
    dec_change = 1;
    @(negedge clk); dec_change = 0;
    drain();
    for (int i = 0; i < 3; i++) push(6'b111001, "R9");
    drain();

    // R11: start beats dec_change
    cmd(1, 1, 16'h7E00, 16'h0081);
    exp_full(32'h7E00_0081, "R11");
    drain();
    check("R7 done held, busy low", {30'd0, busy, done}, 32'd1);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL R7 watchdog expired actual=busy expected=idle");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule